// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block runs single accesses from a fast CPU-side request port onto a slow 16-bit local bus. The local bus serves boot memory, board I/O and an expansion connector. The block produces the local bus clock at half the core clock rate. It drives the address, the upper-byte enable and the write data, and it times active-low read and write strobes in whole local-bus clock periods. A 2-bit setting gives the shortest strobe. When the target is the expansion connector, the cycle can run longer until the device answers on its ready line.

The CPU raises `req` and holds it until `cpu_rdy` drops. `cpu_rdy` stays low for the whole access, so a write is buffered while the CPU is held off. Read data is latched at the edge where the read strobe is released, and `rd_valid` pulses in the following clock. A cycle can stay on the bus for `TMO_CYC` core clocks. If it reaches that limit, the block ends it, clears the active-low sticky flag `tmo_n` and raises `irq`. Driving `tmo_clr` low and then high again clears the flag.

Top module: `lbus_seq`

## Requirements
- R1: `lb_clk` changes level on every core clock edge after reset. A request is accepted at an edge where `req`, `cpu_rdy` and `lb_clk` are all high, and the strobe goes low at that edge.
- R2: For an on-board target (`req_ext`=0), the strobe stays low for exactly 2*(`width_sel`+1) core clocks, and `lb_ready` has no effect on this.
- R3: For an expansion target, the strobe is released at the first even count of low clocks that is at least 2*(`width_sel`+1) and at whose closing edge `lb_ready` is high.
- R4: `lb_rd_n` is used when `req_we`=0 and `lb_wr_n` when `req_we`=1. The two strobes are never low together.
- R5: On a read, `rd_data` takes the `lb_rdata` value present at the edge that releases the strobe. `rd_valid` is high for exactly one clock, the first clock with the strobe high.
- R6: `cpu_rdy` is low from acceptance until the strobe is released. While `lb_wr_n` is low, `lb_wdata` holds the requested data and `lb_wdata_oe` is 1.
- R7: For an on-board target, `lb_bhe` equals `req_be[1]` and `lb_addr` equals `req_addr`. For an expansion target, `lb_bhe`=1 and `lb_addr[0]`=0 (halfword only).
- R8: If a strobe has been low for `TMO_CYC` clocks and the cycle has not ended normally at that same edge, the block releases the strobe, returns `cpu_rdy` (and `rd_valid` on a read), sets `tmo_n`=0 and sets `irq`=1. If the normal end falls on that edge, it takes precedence and the flag is not set.
- R9: `tmo_n` stays 0 while `tmo_clr` is high. It returns to 1 in the clock after `tmo_clr` is sampled low.
- R10: After reset, `lb_rd_n`=1, `lb_wr_n`=1, `cpu_rdy`=1, `rd_valid`=0, `tmo_n`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | Target is the expansion connector |
| req_addr | input | AW | Byte address |
| req_be | input | 2 | Byte enables, bit 1 = bits 15:8 |
| req_wdata | input | DW | Write data |
| width_sel | input | 2 | Minimum strobe length minus one, in local-bus clocks |
| cpu_rdy | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-clock read data valid |
| rd_data | output | DW | Captured read data |
| lb_clk | output | 1 | Local bus clock, half rate |
| lb_addr | output | AW | Local bus address |
| lb_bhe | output | 1 | Upper byte in use |
| lb_rd_n | output | 1 | Read strobe, active low |
| lb_wr_n | output | 1 | Write strobe, active low |
| lb_wdata | output | DW | Buffered write data |
| lb_wdata_oe | output | 1 | Write data drive enable |
| lb_rdata | input | DW | Read data from the local bus |
| lb_ready | input | 1 | Expansion device ready, active high |
| tmo_clr | input | 1 | Flag clear control, pulse low to clear |
| tmo_n | output | 1 | Sticky timeout flag, active low |
| irq | output | 1 | Timeout interrupt request |

## Verification
The bench builds the block with `TMO_CYC`=40 and `AW`=20. With these values the timeout limit is only a few strobe lengths above the longest minimum width of 8 clocks. Random expansion ready delays then land just below, exactly on, and just above the limit. This covers the case where a normal end and the timeout fall on the same edge, the forced termination, and the low-then-high clear handshake many times in a short run.

// File: rtl/lbus_seq.sv
module lbus_seq #(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int TMO_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          req_ext,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    width_sel,
  output logic          cpu_rdy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          lb_clk,
  output logic [AW-1:0] lb_addr,
  output logic          lb_bhe,
  output logic          lb_rd_n,
  output logic          lb_wr_n,
  output logic [DW-1:0] lb_wdata,
  output logic          lb_wdata_oe,
  input  logic [DW-1:0] lb_rdata,
  input  logic          lb_ready,
  input  logic          tmo_clr,
  output logic          tmo_n,
  output logic          irq
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(TMO_CYC - 1);

  logic          ph, busy, we_q, ext_q;
  logic [1:0]    wsel_q;
  logic [2:0]    lcnt;
  logic [TW-1:0] tcnt;
  logic          fin, tmo_hit, accept;

  assign accept  = !busy && req && ph;
  assign fin     = busy && ph && ({1'b0, wsel_q} <= lcnt) && (!ext_q || lb_ready);
  assign tmo_hit = busy && (tcnt == TLAST);

  assign lb_clk      = ph;
  assign cpu_rdy     = !busy;
  assign lb_wdata_oe = !lb_wr_n;
  assign irq         = !tmo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      busy     <= 1'b0;
      we_q     <= 1'b0;
      ext_q    <= 1'b0;
      wsel_q   <= '0;
      lcnt     <= '0;
      tcnt     <= '0;
      lb_rd_n  <= 1'b1;
      lb_wr_n  <= 1'b1;
      lb_addr  <= '0;
      lb_bhe   <= 1'b0;
      lb_wdata <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ph       <= !ph;
      rd_valid <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        we_q     <= req_we;
        ext_q    <= req_ext;
        wsel_q   <= width_sel;
        lcnt     <= '0;
        tcnt     <= '0;
        lb_rd_n  <= req_we;
        lb_wr_n  <= !req_we;
        lb_addr  <= req_ext ? {req_addr[AW-1:1], 1'b0} : req_addr;
        lb_bhe   <= req_ext ? 1'b1 : req_be[1];
        lb_wdata <= req_wdata;
      end else if (busy) begin
        tcnt <= tcnt + 1'b1;
        if (ph && lcnt != 3'd7) lcnt <= lcnt + 1'b1;
        if (fin || tmo_hit) begin
          busy    <= 1'b0;
          lb_rd_n <= 1'b1;
          lb_wr_n <= 1'b1;
          if (!we_q) begin
            rd_valid <= 1'b1;
            rd_data  <= lb_rdata;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tmo_n <= 1'b1;
    else if (!tmo_clr)          tmo_n <= 1'b1;
    else if (tmo_hit && !fin)   tmo_n <= 1'b0;
  end
endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_rdy,
  input logic rd_valid,
  input logic lb_clk,
  input logic lb_rd_n,
  input logic lb_wr_n,
  input logic [15:0] lb_wdata,
  input logic tmo_clr,
  input logic tmo_n
);
  a_r1_clock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lb_clk != $past(lb_clk)));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lb_rd_n && !lb_wr_n));

  a_r5_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(lb_rd_n));

  a_r6_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_wr_n |-> !cpu_rdy);

  a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_wr_n |=> (lb_wr_n || $stable(lb_wdata)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_n && tmo_clr) |=> !tmo_n);
endmodule

bind lbus_seq lbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rdy(cpu_rdy), .rd_valid(rd_valid),
  .lb_clk(lb_clk), .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n),
  .lb_wdata(lb_wdata[15:0]), .tmo_clr(tmo_clr), .tmo_n(tmo_n)
);

// File: tb/sim_lbus_seq.sv
module sim_lbus_seq;
  localparam int AW  = 20;
  localparam int TMO = 40;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0, req_ext = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_be = '0, width_sel = '0;
  logic [15:0] req_wdata = '0, lb_rdata = '0;
  logic lb_ready = 0, tmo_clr = 1;
  logic cpu_rdy, rd_valid, lb_clk, lb_bhe, lb_rd_n, lb_wr_n, lb_wdata_oe, tmo_n, irq;
  logic [15:0] rd_data, lb_wdata;
  logic [AW-1:0] lb_addr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lbus_seq #(.AW(AW), .DW(16), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_ext(req_ext),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .width_sel(width_sel),
    .cpu_rdy(cpu_rdy), .rd_valid(rd_valid), .rd_data(rd_data), .lb_clk(lb_clk),
    .lb_addr(lb_addr), .lb_bhe(lb_bhe), .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n),
    .lb_wdata(lb_wdata), .lb_wdata_oe(lb_wdata_oe), .lb_rdata(lb_rdata),
    .lb_ready(lb_ready), .tmo_clr(tmo_clr), .tmo_n(tmo_n), .irq(irq));

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic int exp_len(input bit ext, input int w, input int r);
    int n, l;
    n = 2 * (w + 1);
    if (!ext) return n;
    l = (r > n) ? r : n;
    if (l % 2 != 0) l++;
    return l;
  endfunction

  task automatic run_cycle(input bit we, input bit ext, input int w, input int r,
                           input logic [AW-1:0] a, input logic [1:0] be,
                           input logic [15:0] wd, input logic [15:0] rdv);
    int cnt, el, guard;
    bit tmo_exp, side_ok, held_ok;
    logic [AW-1:0] ea;
    el = exp_len(ext, w, r);
    tmo_exp = (el > TMO);
    if (tmo_exp) el = TMO;
    ea = ext ? {a[AW-1:1], 1'b0} : a;
    @(negedge clk);
    req = 1; req_we = we; req_ext = ext; width_sel = 2'(w); req_addr = a;
    req_be = be; req_wdata = wd; lb_rdata = rdv; lb_ready = (r == 0);
    guard = 0;
    do begin @(negedge clk); guard++; end while (lb_rd_n && lb_wr_n && guard < 10);
    req = 0;
    cnt = 0; side_ok = 1; held_ok = 1;
    while (!(lb_rd_n && lb_wr_n) && cnt < 200) begin
      cnt++;
      if (cpu_rdy) held_ok = 0;
      if (we && (lb_wr_n || !lb_rd_n || lb_wdata !== wd || !lb_wdata_oe)) held_ok = 0;
      if (!we && !lb_wr_n) side_ok = 0;
      if (lb_addr !== ea || lb_bhe !== (ext ? 1'b1 : be[1])) side_ok = 0;
      if (cnt == r) lb_ready = 1;
      @(negedge clk);
    end
    lb_ready = 0;
    if (tmo_exp) check(cnt == el, "R8 timeout length", cnt, el);
    else if (ext) check(cnt == el, "R3 expansion length", cnt, el);
    else check(cnt == el, "R2 on-board length", cnt, el);
    check(side_ok, "R7 address/bhe", lb_addr, ea);
    check(held_ok, "R6 cpu held / write data", we, 1);
    check(cpu_rdy, "R6 ready returned", cpu_rdy, 1);
    if (!we) check(rd_valid && rd_data == rdv, "R5 read data", rd_data, rdv);
    else check(!rd_valid, "R5 no valid on write", rd_valid, 0);
    check(tmo_n == !tmo_exp && irq == tmo_exp, "R8 flag", tmo_n, !tmo_exp);
    @(negedge clk);
    check(!rd_valid, "R5 single pulse", rd_valid, 0);
    if (tmo_exp) begin
      check(!tmo_n, "R9 flag holds", tmo_n, 0);
      tmo_clr = 0;
      @(negedge clk);
      check(tmo_n && !irq, "R9 flag cleared", tmo_n, 1);
      tmo_clr = 1;
      @(negedge clk);
      check(tmo_n, "R9 stays clear", tmo_n, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(lb_rd_n && lb_wr_n && cpu_rdy && !rd_valid && tmo_n && !irq,
          "R10 reset state", {lb_rd_n, lb_wr_n, cpu_rdy, rd_valid, tmo_n, irq}, 6'b111010);
    rst_n = 1;
    @(negedge clk);
    prev = lb_clk;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(lb_clk != prev, "R1 clock toggles", lb_clk, !prev);
      prev = lb_clk;
    end
    // directed corners
    run_cycle(0, 0, 0, 0, 20'h00013, 2'b01, 16'h0, 16'hA5C3);
    run_cycle(1, 0, 3, 0, 20'h12345, 2'b11, 16'hBEEF, 16'h0);
    run_cycle(0, 0, 1, 0, 20'h00100, 2'b10, 16'h0, 16'h1234);
    run_cycle(0, 1, 0, 0, 20'h00101, 2'b01, 16'h0, 16'h5A5A);
    run_cycle(1, 1, 2, 13, 20'h0F0F1, 2'b01, 16'h7E81, 16'h0);
    run_cycle(0, 1, 3, 39, 20'h00002, 2'b11, 16'h0, 16'hC0DE);
    run_cycle(0, 1, 1, 40, 20'h00004, 2'b11, 16'h0, 16'h0F0F);
    run_cycle(0, 1, 1, 41, 20'h00006, 2'b11, 16'h0, 16'hF00F);
    run_cycle(1, 1, 0, 200, 20'h00008, 2'b11, 16'h3333, 16'h0);
    // random mix
    for (int i = 0; i < 150; i++) begin
      run_cycle(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 50),
                AW'($urandom), 2'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule